// File: doc/BRIEF.md
# Bit-Serial Lookup-Table IIR Filter

This block is a second-order recursive filter that forms each output sample as y(i) = A·x(i) + B·x(i-1) + C·x(i-2) + D·y(i-1) + E·y(i-2) without a single multiplier. Samples are two's-complement words of `SW` bits that enter and leave one bit per clock, least significant bit first. In every bit cycle, one bit from each of the five operands forms a 5-bit address into a 32-word table of precomputed coefficient sums. That table word is added to a shifting accumulator, or subtracted from it on the sign-bit cycle.

The five coefficients are fixed parameters in signed fixed point with `CF` fractional bits, and the table is computed from them at elaboration. The sum is rounded to an integer and saturated to `SW` bits. It is then fed back as the newest output history and shifted out serially, with a one-cycle flag on the first output bit. The surrounding logic pulses `start` with bit 0 of each input sample. Samples may follow each other with no gap, or with any number of idle cycles between them.

Top module: `iir_bitserial_lut`

## Requirements
- R1: After reset, `dout` and `dvalid` are 0 and all four history words are zero, so the first output after reset is round(A·x(0)/2^CF).
- R2: Each output equals the recurrence above, computed exactly on integers, with the coefficients scaled by 2^CF and the saturated previous outputs used as y(i-1) and y(i-2).
- R3: An input sample is taken from `din` over `SW` consecutive cycles, bit 0 in the cycle where `start` is accepted, bit k k cycles later, and bit SW-1 as the two's-complement sign.
- R4: `dvalid` is high for exactly one cycle, the cycle after the last input bit of a sample. In that cycle `dout` carries output bit 0, and bits 1 to SW-1 follow in the next cycles. At all other times `dout` is 0.
- R5: Rounding adds 2^(CF-1) and then floors, so exact halves round toward plus infinity (−0.5 gives 0, +0.5 gives 1, −0.75 gives −1).
- R6: Results above 2^(SW-1)−1 become 2^(SW-1)−1, and results below −2^(SW-1) become −2^(SW-1). Feedback uses the saturated value.
- R7: A `start` pulse during the SW−1 cycles after an accepted `start` has no effect on the sample in progress or on later results.
- R8: Idle cycles between samples leave the history unchanged.
- R9: A `start` in the cycle right after the last bit of the previous sample is accepted, so samples can stream with a period of SW cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial sample input, LSB first |
| start | input | 1 | Marks bit 0 of an input sample |
| dout | output | 1 | Serial filtered output, LSB first |
| dvalid | output | 1 | High with output bit 0 |

## Verification
A corrupted history word or table entry does not stay local: through the feedback term it alters the sample it enters and every later one. It therefore shows up in the words compared at the port within one or two sample periods. A wrong bit counter or sign-cycle choice breaks the sign handling of negative inputs and the timing of `dvalid` at once, so the check on the cycle of the flag catches it on the first sample. Saturation and rounding errors appear only at the extremes and at exact halves, which is why those cases are driven from a fresh reset with values known by hand.

// File: rtl/iir_da_pkg.sv
package iir_da_pkg;
  localparam int NTAP = 5;
  localparam int NENT = 1 << NTAP;

  // Sum of the coefficients selected by the set bits of addr.
  // Bit 0 x(i), bit 1 x(i-1), bit 2 x(i-2), bit 3 y(i-1), bit 4 y(i-2).
  function automatic int tap_sum(input int addr, input int ca, input int cb,
                                 input int cc, input int cd, input int ce);
    int s;
    s = 0;
    if (addr[0]) s += ca;
    if (addr[1]) s += cb;
    if (addr[2]) s += cc;
    if (addr[3]) s += cd;
    if (addr[4]) s += ce;
    return s;
  endfunction
endpackage

// File: rtl/iir_da_rom.sv
module iir_da_rom
  import iir_da_pkg::*;
#(
  parameter int TW = 11,
  parameter int CA = 16,
  parameter int CB = 32,
  parameter int CC = 16,
  parameter int CD = 48,
  parameter int CE = -16
) (
  input  logic [NTAP-1:0]      addr,
  output logic signed [TW-1:0] word
);
  logic signed [TW-1:0] rom [NENT];

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    assign rom[g] = TW'(tap_sum(g, CA, CB, CC, CD, CE));
  end

  assign word = rom[addr];
endmodule

// File: rtl/iir_da_hist.sv
module iir_da_hist
  import iir_da_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            fin,
  input  logic            din,
  input  logic [SW-1:0]   y_new,
  output logic [NTAP-1:0] addr
);
  logic [SW-1:0] xcol, x1, x2, y1, y2;

  function automatic logic [SW-1:0] rot(input logic [SW-1:0] r);
    return {r[0], r[SW-1:1]};
  endfunction

  assign addr = {y2[0], y1[0], x2[0], x1[0], din};

  always_ff @(posedge clk) begin
    if (rst) begin
      xcol <= '0;
      x1   <= '0;
      x2   <= '0;
      y1   <= '0;
      y2   <= '0;
    end else if (fin) begin
      x1   <= {din, xcol[SW-1:1]};
      x2   <= rot(x1);
      y2   <= rot(y1);
      y1   <= y_new;
      xcol <= '0;
    end else if (step) begin
      xcol <= {din, xcol[SW-1:1]};
      x1   <= rot(x1);
      x2   <= rot(x2);
      y1   <= rot(y1);
      y2   <= rot(y2);
    end
  end
endmodule

// File: rtl/iir_da_acc.sv
module iir_da_acc #(
  parameter int SW = 8,
  parameter int TW = 11,
  parameter int CF = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 act,
  input  logic                 first,
  input  logic                 sign_bit,
  input  logic signed [TW-1:0] word,
  output logic [SW-1:0]        y_new
);
  localparam int AW = TW + SW + 2;
  localparam logic signed [AW-1:0] HALF = AW'(2 ** (CF - 1));
  localparam logic signed [AW-1:0] YMAX = AW'(2 ** (SW - 1) - 1);
  localparam logic signed [AW-1:0] YMIN = AW'(-(2 ** (SW - 1)));

  logic signed [AW-1:0] acc, acc_in, term, sum, acc_nxt, rnd, q;

  always_comb begin
    acc_in  = first ? '0 : acc;
    term    = $signed({{(AW-TW){word[TW-1]}}, word}) <<< SW;
    sum     = sign_bit ? (acc_in - term) : (acc_in + term);
    acc_nxt = sum >>> 1;
    rnd     = acc_nxt + HALF;
    q       = rnd >>> CF;
    if (q > YMAX)      y_new = YMAX[SW-1:0];
    else if (q < YMIN) y_new = YMIN[SW-1:0];
    else               y_new = q[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      acc <= '0;
    else if (act) acc <= acc_nxt;
  end
endmodule

// File: rtl/iir_bitserial_lut.sv
module iir_bitserial_lut
  import iir_da_pkg::*;
#(
  parameter int SW = 8,
  parameter int CF = 6,
  parameter int CW = 8,
  parameter int CA = 16,
  parameter int CB = 32,
  parameter int CC = 16,
  parameter int CD = 48,
  parameter int CE = -16
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic start,
  output logic dout,
  output logic dvalid
);
  localparam int TW   = CW + 3;
  localparam int CNTW = $clog2(SW);

  logic [CNTW-1:0]      cnt, bidx;
  logic                 busy, accept, act, last;
  logic [NTAP-1:0]      addr;
  logic signed [TW-1:0] word;
  logic [SW-1:0]        y_new, yout;

  assign accept = start && !busy;
  assign act    = accept || busy;
  assign bidx   = busy ? cnt : '0;
  assign last   = act && (bidx == CNTW'(SW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (act) begin
      busy <= !last;
      cnt  <= last ? '0 : bidx + CNTW'(1);
    end
  end

  iir_da_hist #(.SW(SW)) u_hist (
    .clk   (clk),
    .rst   (rst),
    .step  (act && !last),
    .fin   (last),
    .din   (din),
    .y_new (y_new),
    .addr  (addr)
  );

  iir_da_rom #(.TW(TW), .CA(CA), .CB(CB), .CC(CC), .CD(CD), .CE(CE)) u_rom (
    .addr (addr),
    .word (word)
  );

  iir_da_acc #(.SW(SW), .TW(TW), .CF(CF)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .first    (accept),
    .sign_bit (last),
    .word     (word),
    .y_new    (y_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      yout   <= '0;
      dvalid <= 1'b0;
    end else if (last) begin
      yout   <= y_new;
      dvalid <= 1'b1;
    end else begin
      yout   <= yout >> 1;
      dvalid <= 1'b0;
    end
  end

  assign dout = yout[0];
endmodule

// File: rtl/iir_bitserial_lut_chk.sv
module iir_bitserial_lut_chk #(
  parameter int SW   = 8,
  parameter int CNTW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            last,
  input logic [CNTW-1:0] cnt,
  input logic            dout,
  input logic            dvalid
);
  localparam int OW = $clog2(SW + 1);

  logic          rst_q;
  logic [OW-1:0] ocnt;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      p_reset_idle_r1: assert (!dvalid && !dout)
        else $error("outputs not idle after reset");
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 ocnt <= OW'(SW);
    else if (dvalid)         ocnt <= OW'(1);
    else if (ocnt != OW'(SW)) ocnt <= ocnt + OW'(1);
  end

  p_flag_after_last_r4: assert property (@(posedge clk) disable iff (rst)
    last |=> dvalid);

  p_flag_needs_last_r4: assert property (@(posedge clk) disable iff (rst)
    dvalid |-> $past(last));

  p_quiet_output_r4: assert property (@(posedge clk) disable iff (rst)
    (!dvalid && ocnt == OW'(SW)) |-> !dout);

  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (cnt == $past(cnt) + CNTW'(1)));
endmodule

bind iir_bitserial_lut iir_bitserial_lut_chk #(.SW(SW), .CNTW(CNTW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .last   (last),
  .cnt    (cnt),
  .dout   (dout),
  .dvalid (dvalid)
);

// File: tb/iir_bitserial_lut_bench.sv
module iir_bitserial_lut_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;
  localparam int CF = 6;
  localparam int CA = 16;
  localparam int CB = 32;
  localparam int CC = 16;
  localparam int CD = 48;
  localparam int CE = -16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic start = 1'b0;
  logic dout, dvalid;

  int vectors = 0;
  int miscompares = 0;
  int got_q[$];
  int exp_q[$];
  longint xh1, xh2, yh1, yh2;

  logic [SW-1:0] wbuf;
  int wcnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  iir_bitserial_lut #(.SW(SW), .CF(CF), .CW(8), .CA(CA), .CB(CB), .CC(CC),
                      .CD(CD), .CE(CE)) u_iir_bitserial_lut (
    .clk(clk), .rst(rst), .din(din), .start(start), .dout(dout), .dvalid(dvalid)
  );

  // Output collector: assembles serial words starting at the flag.
  always @(negedge clk) begin
    if (dvalid) begin
      wbuf[0] = dout;
      wcnt = 1;
    end else if (wcnt > 0) begin
      wbuf[wcnt] = dout;
      wcnt++;
      if (wcnt == SW) begin
        got_q.push_back(int'($signed(wbuf)));
        wcnt = 0;
      end
    end
  end

  function automatic int model_push(input int x);
    longint s, q;
    s = CA * x + CB * xh1 + CC * xh2 + CD * yh1 + CE * yh2;
    q = (s + (64'sd1 <<< (CF - 1))) >>> CF;
    if (q > (2 ** (SW - 1) - 1)) q = 2 ** (SW - 1) - 1;
    if (q < -(2 ** (SW - 1)))    q = -(2 ** (SW - 1));
    xh2 = xh1; xh1 = x; yh2 = yh1; yh1 = q;
    return int'(q);
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; din = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    xh1 = 0; xh2 = 0; yh1 = 0; yh2 = 0;
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic send(input int v, input int glitch);
    exp_q.push_back(model_push(v));
    for (int k = 0; k < SW; k++) begin
      @(negedge clk);
      start = (k == 0) || (k == glitch);
      din = v[k];
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start = 1'b0;
      din = 1'b0;
    end
  endtask

  task automatic drain(input string req);
    idle(SW + 2);
    check({req, " word count"}, got_q.size(), exp_q.size());
    for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
      check(req, got_q[k], exp_q[k]);
  endtask

  task automatic t_reset();
    apply_reset();
    @(negedge clk);
    check("R1 dout", dout, 0);
    check("R1 dvalid", dvalid, 0);
    send(40, -1);
    drain("R1");
    if (got_q.size() > 0) check("R1 first word", got_q[0], 10);
  endtask

  task automatic t_impulse();
    apply_reset();
    send(64, -1);
    for (int k = 0; k < 9; k++) send(0, -1);
    drain("R2 R9 impulse");
  endtask

  task automatic t_gaps();
    int vals[6] = '{-77, 13, 100, -1, 55, -128};
    apply_reset();
    foreach (vals[k]) begin
      send(vals[k], -1);
      idle(k + 1);
    end
    drain("R3 R8 gaps");
  endtask

  task automatic t_saturate();
    apply_reset();
    for (int k = 0; k < 14; k++) send(127, -1);
    drain("R6 positive");
    if (got_q.size() > 0) check("R6 top", got_q[got_q.size()-1], 127);
    apply_reset();
    for (int k = 0; k < 14; k++) send(-128, -1);
    drain("R6 negative");
    if (got_q.size() > 0) check("R6 bottom", got_q[got_q.size()-1], -128);
  endtask

  task automatic t_round();
    apply_reset();
    send(-2, -1);
    drain("R5 minus half");
    if (got_q.size() > 0) check("R5 minus half value", got_q[0], 0);
    apply_reset();
    send(2, -1);
    drain("R5 plus half");
    if (got_q.size() > 0) check("R5 plus half value", got_q[0], 1);
    apply_reset();
    send(-3, -1);
    drain("R5 minus three quarters");
    if (got_q.size() > 0) check("R5 minus three quarters value", got_q[0], -1);
  endtask

  task automatic t_glitch();
    apply_reset();
    send(90, 4);
    send(-33, SW - 1);
    send(21, 1);
    drain("R7 mid-sample start");
  endtask

  task automatic t_timing();
    int y;
    apply_reset();
    send(-45, -1);
    send(73, -1);
    y = exp_q[exp_q.size()-1];
    @(negedge clk);
    start = 1'b0; din = 1'b0;
    check("R4 flag", dvalid, 1);
    check("R4 bit0", dout, y & 1);
    for (int k = 1; k < SW; k++) begin
      @(negedge clk);
      check("R4 no flag", dvalid, 0);
      check("R4 bit", dout, (y >> k) & 1);
    end
    @(negedge clk);
    check("R4 quiet dout", dout, 0);
    check("R4 quiet flag", dvalid, 0);
    drain("R4 words");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_impulse();
    t_gaps();
    t_saturate();
    t_round();
    t_glitch();
    t_timing();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule